// File: doc/BRIEF.md
# Keyed windowed watchdog

A windowed watchdog that software services by writing one 8-bit service register. The register holds three fields: a two-bit window selector in bits 7:6, a five-bit key in bits 5:1 and a clock-monitor enable flag in bit 0. After reset the watchdog accepts exactly one configuring write. That write must carry the key. It fixes the window and the monitor flag for good and also counts as the first service. Every later service must repeat the whole stored byte. It must also arrive inside the window: no earlier than the lower limit and before the upper limit, both counted in instruction-cycle ticks since the last restart.

Any violation asserts a registered drive-low enable for an open-drain, active-low fault pin. The block watches the sensed pin level through a synchronizer. It holds the drive for a fixed number of ticks counted once the pin is seen low, then releases it. The service window restarts only after the pin is seen high again. Writes made while the fault sequence is in progress are dropped. Timing stops while the core reports HALT or IDLE.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the fault drive is off, the block is unconfigured, and readback is 0xC1 (window code 11, monitor enable 1). With no write, the fault is raised on the 16384th tick after reset.
- R2: While unconfigured, a write whose bits 5:1 equal 01100 is accepted. It stores bits 7:6 and bit 0, locks the configuration, restarts the window and is exempt from the lower limit.
- R3: While unconfigured, a write with any other key raises a fault and leaves the configuration unchanged and unlocked.
- R4: Once locked, a write is a valid service only if all eight bits equal {window, 01100, monitor}. Any mismatch raises a fault, and the stored fields never change again.
- R5: Window codes 00, 01, 10 and 11 select lower/upper limits of 256/2048, 512/4096, 1024/8192 and 2048/16384 ticks.
- R6: A locked service arriving while fewer than the lower limit of ticks have passed since the last restart raises a fault. One arriving at exactly the lower limit is valid and restarts the window.
- R7: Without a valid service, the fault is raised by the tick that makes the count since the last restart equal the upper limit.
- R8: The fault drive is registered and rises at the clock edge that samples the error. The pin level passes a two-stage synchronizer. The drive is released after 16 ticks on which the synchronized level is low; it stays on while the pin reads high.
- R9: After release, the window restarts from zero once the synchronized pin level is high. Writes made from the error edge until that restart are ignored.
- R10: While halt_i or idle_i is high, the tick count is frozen and no timeout fault occurs.
- R11: Readback returns {window, 00000, monitor}; the key bits always read as zero.
- R12: The window count advances only on clock edges where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-cycle tick enable |
| halt_i | input | 1 | Core is in HALT; watchdog timing inhibited |
| idle_i | input | 1 | Core is in IDLE; watchdog timing inhibited |
| wr_en_i | input | 1 | Service register write strobe |
| wdata_i | input | 8 | Service register write data |
| rdata_o | output | 8 | Service register readback |
| pin_i | input | 1 | Sensed level of the fault pin |
| fault_drv_o | output | 1 | Drive-low enable for the open-drain fault pin |

## Verification
A write is judged at the edge that samples it, so a rejected or late write shows on fault_drv_o at the next falling edge. With a write placed n cycles after the previous restart, the design sees a count of n, and the bench places boundary writes at exactly the lower limit and one cycle before it. With ticks every cycle and the pin following the drive, the drive is high for 18 cycles: two synchronizer stages plus 16 hold ticks. The window restarts three cycles after release, and the bench waits exactly that long before the next write. Timeout checks sample one cycle before and at the predicted edge, including runs with a halted or gated tick, where the frozen cycles are added to the expected time.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int unsigned KEY_W = 5;
  localparam logic [KEY_W-1:0] SVC_KEY = 5'b01100;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned REG_W = SEL_W + KEY_W + 1;

  typedef logic [SEL_W-1:0] win_sel_t;

  typedef enum logic [1:0] {
    FLT_RUN     = 2'd0,
    FLT_DRIVE   = 2'd1,
    FLT_WAIT_HI = 2'd2
  } flt_state_e;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import keyed_wdog_pkg::*;
#(
  parameter win_sel_t WIN_RST = 2'b11,
  parameter logic     MON_RST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             locked_o,
  output win_sel_t         win_o,
  output logic             mon_o,
  output logic             acc_o,
  output logic             rej_o
);
  logic     locked_q;
  win_sel_t win_q;
  logic     mon_q;
  logic     match;

  // unlocked: key only; locked: whole byte against stored fields
  always_comb begin
    if (locked_q) match = (wdata_i == {win_q, SVC_KEY, mon_q});
    else          match = (wdata_i[KEY_W:1] == SVC_KEY);
  end

  assign acc_o = wr_i & match;
  assign rej_o = wr_i & ~match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      win_q    <= WIN_RST;
      mon_q    <= MON_RST;
    end else if (acc_o && !locked_q) begin
      locked_q <= 1'b1;
      win_q    <= wdata_i[REG_W-1 -: SEL_W];
      mon_q    <= wdata_i[0];
    end
  end

  assign locked_o = locked_q;
  assign win_o    = win_q;
  assign mon_o    = mon_q;

  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  // R4
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable({win_q, mon_q}));
  // R3
  bad_key_no_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_o && !locked_q) |=> (!locked_q && $stable({win_q, mon_q})));
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned LO_BASE = 256,
  parameter int unsigned HI_BASE = 2048
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  logic     hold_i,
  input  logic     svc_i,
  input  logic     locked_i,
  input  win_sel_t win_i,
  output logic     err_early_o,
  output logic     err_late_o
);
  localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
  localparam int unsigned CNT_W   = $clog2(HI_BASE << MAX_SEL) + 1;

  logic [CNT_W-1:0] cnt_q, lo_lim, hi_lim;
  logic adv, good;

  assign lo_lim = CNT_W'(LO_BASE) << win_i;
  assign hi_lim = CNT_W'(HI_BASE) << win_i;

  // first (configuring) write is exempt from the lower bound
  assign err_early_o = svc_i & locked_i & (cnt_q < lo_lim);
  assign good        = svc_i & ~err_early_o;
  assign adv         = run_i & tick_i & ~hold_i;
  assign err_late_o  = adv & ~good & (cnt_q == hi_lim - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || good)      cnt_q <= '0;
    else if (adv && !err_late_o)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < hi_lim);
  // R10
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i && !svc_i) |=> (cnt_q == $past(cnt_q)));
  // R12
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !svc_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic tick_i,
  input  logic sense_i,
  output logic run_o,
  output logic drive_o
);
  localparam int unsigned HC_W = $clog2(HOLD + 1);

  flt_state_e      st_q;
  logic            drv_q;
  logic [HC_W-1:0] hc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FLT_RUN;
      drv_q <= 1'b0;
      hc_q  <= '0;
    end else begin
      case (st_q)
        FLT_RUN: if (err_i) begin
          st_q  <= FLT_DRIVE;
          drv_q <= 1'b1;
          hc_q  <= '0;
        end
        FLT_DRIVE: begin
          if (sense_i) hc_q <= '0;  // hold time counts only while pin reads low
          else if (tick_i) begin
            if (hc_q == HC_W'(HOLD - 1)) begin
              st_q  <= FLT_WAIT_HI;
              drv_q <= 1'b0;
              hc_q  <= '0;
            end else hc_q <= hc_q + HC_W'(1);
          end
        end
        FLT_WAIT_HI: if (sense_i) st_q <= FLT_RUN;
        default: begin
          st_q  <= FLT_RUN;
          drv_q <= 1'b0;
        end
      endcase
    end
  end

  assign run_o   = (st_q == FLT_RUN);
  assign drive_o = drv_q;

  // R8
  drive_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $past(err_i));
  // R8
  drive_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_q) |-> !$past(sense_i));
  // R9
  wait_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FLT_WAIT_HI && !sense_i) |=> (st_q == FLT_WAIT_HI));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned LO_BASE     = 256,
  parameter int unsigned HI_BASE     = 2048,
  parameter int unsigned HOLD_TICKS  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             idle_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             pin_i,
  output logic             fault_drv_o
);
  logic     run, wr_go, locked, mon, acc, rej;
  logic     err_early, err_late, err, sense;
  win_sel_t win;

  assign wr_go = wr_en_i & run;
  assign err   = rej | err_early | err_late;

  wdog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sense)
  );

  wdog_cfg #(.WIN_RST(2'b11), .MON_RST(1'b1)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_go),
    .wdata_i (wdata_i),
    .locked_o(locked),
    .win_o   (win),
    .mon_o   (mon),
    .acc_o   (acc),
    .rej_o   (rej)
  );

  wdog_window #(.LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick_i),
    .hold_i     (halt_i | idle_i),
    .svc_i      (acc),
    .locked_i   (locked),
    .win_i      (win),
    .err_early_o(err_early),
    .err_late_o (err_late)
  );

  wdog_fault #(.HOLD(HOLD_TICKS)) i_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (err),
    .tick_i (tick_i),
    .sense_i(sense),
    .run_o  (run),
    .drive_o(fault_drv_o)
  );

  assign rdata_o = {win, {KEY_W{1'b0}}, mon};

  // R9
  ignore_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !run) |=> $stable(rdata_o));
endmodule

// File: tb/test_keyed_wdog.sv
`timescale 1ns/1ps
module test_keyed_wdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1, halt = 1'b0, idle = 1'b0;
  logic       wr_en = 1'b0, force_hi = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       drv;
  logic       pin;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  // open-drain pad with pull-up; force_hi models an external fight
  assign pin = (drv && !force_hi) ? 1'b0 : 1'b1;

  keyed_wdog i_keyed_wdog (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halt_i(halt), .idle_i(idle),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .fault_drv_o(drv)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; halt = 1'b0; idle = 1'b0; tick = 1'b1; force_hi = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  // called at a falling edge; write is sampled on the next rising edge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic recover();
    for (int i = 0; i < 200 && drv; i++) @(negedge clk);
    wait_cyc(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 drive after reset", drv, 0);
    chk("R1 readback after reset", rdata, 8'hC1);
    wait_cyc(16383);
    chk("R1 default window not yet expired", drv, 0);
    wait_cyc(1);
    chk("R1 default window expiry", drv, 1);
  endtask

  task automatic t_bad_first();
    int n;
    do_reset();
    wr(8'h00);
    chk("R3 bad first key faults", drv, 1);
    wr(8'h18);  // during drive: ignored
    n = 2;
    for (int i = 0; i < 100 && drv; i++) begin
      @(negedge clk);
      if (drv) n++;
    end
    chk("R8 pulse length", 16'(n), 18);
    wr(8'h18);  // while waiting for pin high: ignored
    wait_cyc(2);
    chk("R9 writes during fault ignored", rdata, 8'hC1);
    chk("R3 config unchanged", rdata, 8'hC1);
    wr(8'h19);
    chk("R2 keyed first write accepted", drv, 0);
    chk("R11 readback key bits zero", rdata, 8'h01);
    wait_cyc(2047);
    chk("R2 first write restarts window", drv, 0);
    wait_cyc(1);
    chk("R2 new window in force", drv, 1);
  endtask

  task automatic t_window(input int w);
    int lo = 256 << w;
    int up = 2048 << w;
    logic [7:0] cfg = {w[1:0], 5'b01100, 1'b0};
    do_reset();
    wr(cfg);
    chk("R2 first write exempt from lower limit", drv, 0);
    chk("R11 readback", rdata, {w[1:0], 6'b0});
    wait_cyc(lo - 1);
    wr(cfg);
    chk("R6 early service faults", drv, 1);
    do_reset();
    wr(cfg);
    wait_cyc(lo);
    wr(cfg);
    chk("R6 service at lower limit valid", drv, 0);
    wait_cyc(up - 1);
    chk("R5 no fault before upper limit", drv, 0);
    wait_cyc(1);
    chk("R7 fault at upper limit", drv, 1);
  endtask

  task automatic t_mismatch();
    do_reset();
    wr(8'h18);
    wait_cyc(256);
    wr(8'h1A);
    chk("R4 key mismatch faults", drv, 1);
    recover(); wait_cyc(256);
    wr(8'h58);
    chk("R4 window mismatch faults", drv, 1);
    recover(); wait_cyc(256);
    wr(8'h19);
    chk("R4 monitor mismatch faults", drv, 1);
    recover();
    chk("R4 config never changes", rdata, 8'h00);
    wait_cyc(256);
    wr(8'h18);
    chk("R4 full match is valid", drv, 0);
  endtask

  task automatic t_inhibit(input bit use_idle, input int len);
    do_reset();
    wr(8'h18);
    wait_cyc(100);
    if (use_idle) idle = 1'b1; else halt = 1'b1;
    wait_cyc(len);
    chk("R10 no timeout while inhibited", drv, 0);
    halt = 1'b0; idle = 1'b0;
    wait_cyc(2048 - 100 - 1);
    chk("R10 count frozen, not yet expired", drv, 0);
    wait_cyc(1);
    chk("R10 expiry after resumed count", drv, 1);
  endtask

  task automatic t_tick();
    do_reset();
    wr(8'h18);
    tick = 1'b0;
    wait_cyc(600);
    tick = 1'b1;
    wr(8'h18);
    chk("R12 no ticks means service is early", drv, 1);
  endtask

  task automatic t_stuck();
    do_reset();
    force_hi = 1'b1;
    wr(8'h00);
    chk("R8 drive asserted", drv, 1);
    wait_cyc(100);
    chk("R8 drive held while pin reads high", drv, 1);
    force_hi = 1'b0;
    wait_cyc(17);
    chk("R8 drive held through hold ticks", drv, 1);
    wait_cyc(1);
    chk("R8 drive released after hold ticks", drv, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bad_first();
    for (int w = 0; w < 4; w++) t_window(w);
    t_mismatch();
    t_inhibit(1'b0, 3000);
    t_inhibit(1'b1, 500);
    t_tick();
    t_stuck();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule